// File: doc/BRIEF.md
# Edge-Kicked Watchdog Timer

This block watches a single level driven by processor software and raises a reset request when that level stops changing. Every change of level, high-to-low as well as low-to-high, restarts the timeout, so the software can kick the watchdog by setting the pin low at the top of its main loop and high inside each routine, instead of pulsing it. When a full timeout passes with no change, the block emits a strobe one clock wide toward the reset generator.

While the reset generator holds its reset-active status, the count is forced to zero. Timing starts again once that status drops. A pin that stays stuck therefore produces a train of reset pulses, one per timeout plus reset length. While the system runs from its backup battery, the block is idle and ignores the pin. The raw pin is asynchronous and passes through a two-flop synchronizer before edge detection. The timeout is a parameter counted in clock ticks. Its default is 1.65 s at 50 MHz.

Top module: `edge_watchdog`

## Requirements
- R1: While `rst_n` is low, `expire_o` is 0. With the pin constant and both hold inputs low from release, `expire_o` is first high in the cycle after the TIMEOUT_TICKS-th rising clock edge following release.
- R2: A low-to-high change of `wdi_i` restarts the timeout. If the new level is first sampled at clock edge m and then held, `expire_o` is high in the cycle after edge m+TIMEOUT_TICKS+2 and low before it.
- R3: A high-to-low change of `wdi_i` restarts the timeout with the same timing as R2.
- R4: `expire_o` matches a cycle-accurate model of sync (2 flops), edge detect, count and saturate on every clock.
- R5: `expire_o` is high for exactly one cycle per expiry. It does not rise again until a level change or a hold clears the count.
- R6: While `rst_active_i` is 1, the count stays zero and `expire_o` stays 0. If edge h is the last edge that samples it high, the next expiry is in the cycle after edge h+TIMEOUT_TICKS.
- R7: With the pin stuck and a reset generator that holds `rst_active_i` for P cycles after each strobe, strobes recur at a fixed period.
- R8: While `on_battery_i` is 1, `expire_o` stays 0 and level changes of `wdi_i` have no effect. After release, timing matches R6.
- R9: A level held for a single clock cycle counts as a change, so a one-cycle pulse restarts the timeout.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| wdi_i | input | 1 | Raw watchdog pin from software, asynchronous |
| rst_active_i | input | 1 | Reset generator is holding reset; clears and holds the timer |
| on_battery_i | input | 1 | System on backup battery; the block idles |
| expire_o | output | 1 | One-cycle timeout strobe to the reset generator |

## Verification
A wrong count or a missed edge appears at `expire_o` as a strobe that arrives early, arrives late or never arrives. It becomes visible within one timeout after the fault. A broken synchronizer depth shifts every expiry by a fixed number of cycles. The bench compares the strobe with a model on every clock and also measures the exact distances between kick and strobe, so an off-by-one surfaces at the first expiry. A failure to saturate shows up as a second strobe one timeout later.

// File: rtl/edge_wdg_pkg.sv
package edge_wdg_pkg;
  // counter width able to hold the value TIMEOUT (saturation point)
  function automatic int count_bits(input int ticks);
    return $clog2(ticks + 1);
  endfunction
endpackage

// File: rtl/edge_wdg_sync.sv
module edge_wdg_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic raw_i,
  output logic sync_o
);
  logic [STAGES-1:0] chain_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) chain_q <= '0;
    else        chain_q <= {chain_q[STAGES-2:0], raw_i};
  end

  assign sync_o = chain_q[STAGES-1];
endmodule

// File: rtl/edge_wdg_edge.sv
module edge_wdg_edge (
  input  logic clk,
  input  logic rst_n,
  input  logic level_i,
  output logic kick_o
);
  logic prev_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) prev_q <= 1'b0;
    else        prev_q <= level_i;
  end

  // either polarity of change counts
  assign kick_o = level_i ^ prev_q;
endmodule

// File: rtl/edge_wdg_timer.sv
module edge_wdg_timer #(
  parameter int TIMEOUT_TICKS = 16,
  parameter int CW            = 5
) (
  input  logic clk,
  input  logic rst_n,
  input  logic kick_i,
  input  logic hold_i,
  output logic expire_o
);
  localparam logic [CW-1:0] LAST = CW'(TIMEOUT_TICKS - 1);
  localparam logic [CW-1:0] FULL = CW'(TIMEOUT_TICKS);

  logic [CW-1:0] cnt_q;
  logic          expire_q;
  logic          clear;

  assign clear = hold_i | kick_i;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q    <= '0;
      expire_q <= 1'b0;
    end else begin
      expire_q <= 1'b0;
      if (clear) begin
        cnt_q <= '0;
      end else if (cnt_q != FULL) begin
        cnt_q <= cnt_q + 1'b1;
        if (cnt_q == LAST) expire_q <= 1'b1;
      end
    end
  end

  assign expire_o = expire_q;

  // R2
  kick_clears_chk: assert property (@(posedge clk) disable iff (!rst_n)
    kick_i |=> (cnt_q == '0));
  // R6
  hold_clears_chk: assert property (@(posedge clk) disable iff (!rst_n)
    hold_i |=> (cnt_q == '0) && !expire_q);
  // R4
  strobe_at_full_chk: assert property (@(posedge clk) disable iff (!rst_n)
    expire_q |-> (cnt_q == FULL));
endmodule

// File: rtl/edge_watchdog.sv
module edge_watchdog #(
  parameter int TIMEOUT_TICKS = 82_500_000,
  parameter int SYNC_STAGES   = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic wdi_i,
  input  logic rst_active_i,
  input  logic on_battery_i,
  output logic expire_o
);
  import edge_wdg_pkg::*;
  localparam int CW = count_bits(TIMEOUT_TICKS);

  logic level;
  logic kick;
  logic hold;

  assign hold = rst_active_i | on_battery_i;

  edge_wdg_sync #(.STAGES(SYNC_STAGES)) u_sync (
    .clk(clk), .rst_n(rst_n), .raw_i(wdi_i), .sync_o(level));

  edge_wdg_edge u_edge (
    .clk(clk), .rst_n(rst_n), .level_i(level), .kick_o(kick));

  edge_wdg_timer #(.TIMEOUT_TICKS(TIMEOUT_TICKS), .CW(CW)) u_timer (
    .clk(clk), .rst_n(rst_n), .kick_i(kick), .hold_i(hold),
    .expire_o(expire_o));

  // R5
  single_strobe_chk: assert property (@(posedge clk) disable iff (!rst_n)
    expire_o |=> !expire_o);
  // R6
  no_strobe_in_reset_chk: assert property (@(posedge clk) disable iff (!rst_n)
    rst_active_i |=> !expire_o);
  // R8
  idle_on_battery_chk: assert property (@(posedge clk) disable iff (!rst_n)
    on_battery_i |=> !expire_o);
endmodule

// File: tb/tb_edge_watchdog.sv
module tb_edge_watchdog;
  localparam int LIMIT = 24;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic wdi = 1'b0;
  logic rst_active = 1'b0;
  logic on_batt = 1'b0;
  logic expire;

  int checks = 0;
  int fails = 0;
  int cyc = 0;
  bit done = 1'b0;

  always #10 clk = ~clk;

  edge_watchdog #(.TIMEOUT_TICKS(LIMIT)) dut (
    .clk(clk), .rst_n(rst_n), .wdi_i(wdi), .rst_active_i(rst_active),
    .on_battery_i(on_batt), .expire_o(expire));

  task automatic check(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%0d expected=%0d t=%0t", req, act, exp, $time);
    end
  endtask

  task automatic finish_run();
    if (!done) begin
      done = 1'b1;
      $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
    end
  endtask

  // behavioural reference: history of sampled pin levels, saturating count
  bit q[$];
  int m_cnt;
  bit m_exp;
  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      q = '{1'b0, 1'b0, 1'b0};
      m_cnt = 0;
      m_exp = 1'b0;
    end else begin
      bit kick, hold;
      kick = (q[1] != q[2]);
      hold = rst_active | on_batt;
      m_exp = 1'b0;
      if (hold || kick) m_cnt = 0;
      else if (m_cnt == LIMIT - 1) begin m_cnt = LIMIT; m_exp = 1'b1; end
      else if (m_cnt < LIMIT) m_cnt++;
      q.push_front(wdi);
      void'(q.pop_back());
    end
  end

  // R4: every-cycle comparison against the model
  always @(posedge clk) begin
    #5;
    if (rst_n && !done) check(expire == m_exp, "R4 model", expire, m_exp);
  end

  always @(posedge clk) begin
    cyc++;
    if (cyc > 20000 && !done) begin
      check(1'b0, "watchdog", cyc, 20000);
      finish_run();
    end
  end

  task automatic count_to_expire(output int n);
    n = 0;
    do begin
      @(posedge clk); #5; n++;
    end while (!expire && n < 4 * LIMIT);
  endtask

  initial begin
    int n, seen;
    repeat (3) @(negedge clk);
    check(expire == 1'b0, "R1 in reset", expire, 0);
    rst_n = 1'b1;
    count_to_expire(n);
    check(n == LIMIT, "R1 first expiry", n, LIMIT);

    // R5: saturated, no second strobe
    seen = 0;
    repeat (3 * LIMIT) begin @(posedge clk); #5; if (expire) seen++; end
    check(seen == 0, "R5 no repeat", seen, 0);

    // R2: rising edge
    @(negedge clk); wdi = 1'b1;
    count_to_expire(n);
    check(n == LIMIT + 3, "R2 rising kick", n, LIMIT + 3);

    // R3: falling edge
    @(negedge clk); wdi = 1'b0;
    count_to_expire(n);
    check(n == LIMIT + 3, "R3 falling kick", n, LIMIT + 3);

    // R9: one-cycle pulse mid-timeout restarts
    @(negedge clk); wdi = 1'b1;
    repeat (LIMIT / 2) @(negedge clk);
    wdi = 1'b0;
    @(negedge clk); wdi = 1'b1;
    count_to_expire(n);
    check(n == LIMIT + 3, "R9 short pulse", n, LIMIT + 3);

    // R6: hold from reset generator
    @(negedge clk); rst_active = 1'b1;
    seen = 0;
    repeat (10) begin @(posedge clk); #5; if (expire) seen++; end
    @(negedge clk); rst_active = 1'b0;
    check(seen == 0, "R6 quiet in reset", seen, 0);
    count_to_expire(n);
    check(n == LIMIT, "R6 restart after reset", n, LIMIT);

    // R8: battery mode ignores the pin
    @(negedge clk); on_batt = 1'b1;
    seen = 0;
    for (int i = 0; i < 2 * LIMIT; i++) begin
      if (i % 5 == 0 && i < 2 * LIMIT - 8) wdi = ~wdi;
      @(posedge clk); #5; if (expire) seen++;
      @(negedge clk);
    end
    check(seen == 0, "R8 quiet on battery", seen, 0);
    on_batt = 1'b0;
    count_to_expire(n);
    check(n == LIMIT, "R8 restart after battery", n, LIMIT);

    // R7: stuck pin with a 5-cycle reset generator
    for (int k = 0; k < 3; k++) begin
      @(negedge clk); rst_active = 1'b1;
      repeat (5) @(negedge clk);
      rst_active = 1'b0;
      count_to_expire(n);
      check(n == LIMIT, "R7 periodic pulse", n, LIMIT);
    end

    repeat (4) @(negedge clk);
    finish_run();
  end
endmodule